// File: doc/BRIEF.md
# Sigma-Delta Bitstream Comb Decimator

This block turns the one-bit output of a sigma-delta modulator into a signed multi-bit word, once per converter switching period, for a digital loop compensator. It runs on the modulator clock. Every clock it adds the incoming bit to a running count of ones. At the end of each window it dumps that count, re-centres it about mid-scale and scales it into a fixed-width word. It then clears the count for the next window.

The window length is given in modulator clocks on `per_len`. A `period_sync` strobe starts the first window and can restart a window at any time. After that the block runs freely, one window after another, and takes up a new length only at a window boundary. The word is left-aligned to `OUT_W` bits, so a full-scale input gives full scale whatever the period. The effective resolution is reported beside each word, and it falls by one bit each time the switching frequency doubles. With a 25 MHz modulator clock, a 250-clock window (100 kHz) gives 8 bits and a 125-clock window (200 kHz) gives 7 bits.

For a slow, bandwidth-limited path, the parameter `FIXED_WIN` replaces the port with a constant long window and leaves the rest of the structure the same. Windows longer than the output word can resolve are scaled down by an arithmetic right shift.

Top module: `sd_comb_decim`

## Requirements
- R1: During and directly after reset, `sample_valid` is 0, `sample` is 0 and `eff_bits` is 0.
- R2: Until the first `period_sync`, the block ignores the bitstream and produces no `sample_valid`.
- R3: Each window of L bits produces exactly one `sample_valid`, one clock wide. It is high in the cycle after the clock edge that takes the window's last bit.
- R4: With N ones in a window of length L and resolution r, the value c = 2N − L is a two's-complement number. `sample` is c shifted left by OUT_W−1−r.
- R5: `eff_bits` reports r = ceil(log2 L), the bit count of L−1 (8 for L = 250, 7 for L = 125, 2 for L = 4). It changes only together with a new sample.
- R6: After a window ends, the next window begins on the very next clock without a strobe. Its length is the clamped `per_len` present at the ending clock.
- R7: A result above 2^(OUT_W−1)−1 or below −2^(OUT_W−1) is saturated to that limit. An all-ones window of L = 256 gives 2047 for OUT_W = 12.
- R8: A `per_len` below 4 is treated as 4.
- R9: A change of `per_len` in the middle of a window does not alter that window's length. It takes effect from the next boundary.
- R10: `period_sync` throws away the partial window, with no `sample_valid` in that cycle or the next. It starts a new window whose first bit is the one present with the strobe, using the `per_len` present with it.
- R11: When r exceeds OUT_W−1, `sample` is c arithmetically shifted right by r−(OUT_W−1). For example, an all-ones window of L = 3000 gives 1500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_bit | input | 1 | Modulator bitstream, one bit per clock |
| per_len | input | PER_W | Window length in modulator clocks |
| period_sync | input | 1 | Start-of-period strobe; restarts the window |
| sample | output | OUT_W | Signed, left-aligned decimated word |
| sample_valid | output | 1 | One-clock pulse marking a new `sample` |
| eff_bits | output | $clog2(PER_W+1) | Effective resolution of the current `sample` |

## Verification
A window that starts at the clock edge taking its first bit ends L edges later. `sample`, `sample_valid` and `eff_bits` all change at that final edge, so they are due one register stage after the last bit. The bench drives each bit at the falling edge and reads the outputs 1 ns after the following rising edge. For every intermediate bit it requires `sample_valid` to stay low, and it compares the word and the resolution exactly at the edge that takes the final bit. A restart strobe and a mid-window length change are placed on a known bit index, so the expected window length, and with it the expected pulse cycle, is fixed before the check.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_RUN  = 1'b1
   } win_state_e;

   // smallest r with 2**r >= v (v >= 1)
   function automatic int unsigned ceil_log2_f(input logic [31:0] v);
      int unsigned r;
      r = 0;
      for (int i = 0; i < 32; i++) begin
         if (((v - 32'd1) >> i) != 32'd0) r = i + 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/sd_window_ctl.sv
module sd_window_ctl
   import sd_decim_pkg::*;
#(
   parameter int PER_W     = 16,
   parameter int MIN_PER   = 4,
   parameter int FIXED_WIN = 0,
   parameter int RES_W     = $clog2(PER_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic [PER_W-1:0] per_len_i,
   output logic             run_o,
   output logic             dump_o,
   output logic [PER_W-1:0] cnt_o,
   output logic [PER_W-1:0] len_o,
   output logic [RES_W-1:0] res_o
);

   localparam logic [PER_W-1:0] MIN_LEN = PER_W'(MIN_PER);

   win_state_e       st_q;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] len_q;
   logic [RES_W-1:0] res_q;
   logic [PER_W-1:0] nxt_len;
   logic [RES_W-1:0] nxt_res;

   generate
      if (FIXED_WIN == 0) begin : g_port_len
         always_comb nxt_len = (per_len_i < MIN_LEN) ? MIN_LEN : per_len_i;
      end else begin : g_fixed_len
         logic per_len_unused;
         assign per_len_unused = ^per_len_i;
         assign nxt_len = PER_W'(FIXED_WIN);
      end
   endgenerate

   always_comb nxt_res = RES_W'(ceil_log2_f(32'(nxt_len)));

   assign run_o  = (st_q == WIN_RUN);
   assign dump_o = run_o && !sync_i && (cnt_q == len_q - PER_W'(1));
   assign cnt_o  = cnt_q;
   assign len_o  = len_q;
   assign res_o  = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WIN_IDLE;
         cnt_q <= '0;
         len_q <= MIN_LEN;
         res_q <= '0;
      end else if (sync_i) begin
         st_q  <= WIN_RUN;
         cnt_q <= PER_W'(1);
         len_q <= nxt_len;
         res_q <= nxt_res;
      end else if (dump_o) begin
         cnt_q <= '0;
         len_q <= nxt_len;
         res_q <= nxt_res;
      end else if (run_o) begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

   p_len_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (len_q >= MIN_LEN));

   p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !sync_i && !dump_o) |=> $stable(len_q));

   p_cnt_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (cnt_q < len_q));

endmodule

// File: rtl/sd_ones_integrator.sv
module sd_ones_integrator #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_i,
   input  logic             sync_i,
   input  logic             dump_i,
   input  logic             run_i,
   output logic [PER_W-1:0] acc_o,
   output logic [PER_W-1:0] total_o
);

   logic [PER_W-1:0] acc_q;

   assign acc_o   = acc_q;
   assign total_o = acc_q + PER_W'(bit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (sync_i) acc_q <= PER_W'(bit_i);
      else if (dump_i) acc_q <= '0;
      else if (run_i)  acc_q <= total_o;
   end

endmodule

// File: rtl/sd_align_sat.sv
module sd_align_sat #(
   parameter int PER_W = 16,
   parameter int OUT_W = 12,
   parameter int RES_W = $clog2(PER_W + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dump_i,
   input  logic [PER_W-1:0]        total_i,
   input  logic [PER_W-1:0]        len_i,
   input  logic [RES_W-1:0]        res_i,
   output logic signed [OUT_W-1:0] sample_o,
   output logic                    valid_o,
   output logic [RES_W-1:0]        bits_o
);

   localparam int WW  = PER_W + 2 + OUT_W;
   localparam int TOP = OUT_W - 1;
   localparam logic [RES_W-1:0]        TOP_R = RES_W'(TOP);
   localparam logic signed [WW-1:0]    MAXV  = (WW'(1) << TOP) - WW'(1);
   localparam logic signed [WW-1:0]    MINV  = ~MAXV;

   logic signed [PER_W+1:0] centred;
   logic signed [WW-1:0]    wide;
   logic signed [WW-1:0]    shifted;
   logic signed [OUT_W-1:0] sat_v;

   logic signed [OUT_W-1:0] sample_q;
   logic                    valid_q;
   logic [RES_W-1:0]        bits_q;

   always_comb begin
      centred = $signed({1'b0, total_i, 1'b0}) - $signed({2'b00, len_i});
      wide    = {{OUT_W{centred[PER_W+1]}}, centred};
      if (res_i <= TOP_R) shifted = wide <<< (TOP_R - res_i);
      else                shifted = wide >>> (res_i - TOP_R);
      if (shifted > MAXV)      sat_v = MAXV[OUT_W-1:0];
      else if (shifted < MINV) sat_v = MINV[OUT_W-1:0];
      else                     sat_v = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         valid_q  <= 1'b0;
         bits_q   <= '0;
      end else begin
         valid_q <= dump_i;
         if (dump_i) begin
            sample_q <= sat_v;
            bits_q   <= res_i;
         end
      end
   end

   assign sample_o = sample_q;
   assign valid_o  = valid_q;
   assign bits_o   = bits_q;

   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   p_bits_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !dump_i |=> $stable(bits_q));

   p_sample_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dump_i |=> $stable(sample_q));

endmodule

// File: rtl/sd_comb_decim.sv
module sd_comb_decim #(
   parameter int OUT_W     = 12,
   parameter int PER_W     = 16,
   parameter int MIN_PER   = 4,
   parameter int FIXED_WIN = 0,
   parameter int RES_W     = $clog2(PER_W + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sd_bit,
   input  logic [PER_W-1:0]        per_len,
   input  logic                    period_sync,
   output logic signed [OUT_W-1:0] sample,
   output logic                    sample_valid,
   output logic [RES_W-1:0]        eff_bits
);

   generate
      if (OUT_W < 4 || OUT_W > PER_W) begin : g_bad_out_w
         $error("sd_comb_decim: OUT_W must lie in 4..PER_W");
      end
      if (PER_W < 3 || PER_W > 30) begin : g_bad_per_w
         $error("sd_comb_decim: PER_W must lie in 3..30");
      end
      if (MIN_PER < 2 || MIN_PER >= (1 << PER_W)) begin : g_bad_min
         $error("sd_comb_decim: MIN_PER out of range");
      end
      if (FIXED_WIN != 0 && (FIXED_WIN < MIN_PER || FIXED_WIN >= (1 << PER_W))) begin : g_bad_fixed
         $error("sd_comb_decim: FIXED_WIN out of range");
      end
   endgenerate

   logic             run;
   logic             dump;
   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] len;
   logic [RES_W-1:0] res;
   logic [PER_W-1:0] acc;
   logic [PER_W-1:0] total;

   sd_window_ctl #(
      .PER_W    (PER_W),
      .MIN_PER  (MIN_PER),
      .FIXED_WIN(FIXED_WIN),
      .RES_W    (RES_W)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (period_sync),
      .per_len_i(per_len),
      .run_o    (run),
      .dump_o   (dump),
      .cnt_o    (cnt),
      .len_o    (len),
      .res_o    (res)
   );

   sd_ones_integrator #(
      .PER_W(PER_W)
   ) u_int (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_i  (sd_bit),
      .sync_i (period_sync),
      .dump_i (dump),
      .run_i  (run),
      .acc_o  (acc),
      .total_o(total)
   );

   sd_align_sat #(
      .PER_W(PER_W),
      .OUT_W(OUT_W),
      .RES_W(RES_W)
   ) u_aln (
      .clk     (clk),
      .rst_n   (rst_n),
      .dump_i  (dump),
      .total_i (total),
      .len_i   (len),
      .res_i   (res),
      .sample_o(sample),
      .valid_o (sample_valid),
      .bits_o  (eff_bits)
   );

   p_ones_le_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (acc <= cnt));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sample_valid);

   p_sync_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      period_sync |=> !sample_valid);

endmodule

// File: tb/tb_sd_comb_decim.sv
`timescale 1ns/1ps
module tb_sd_comb_decim;

   localparam int OUT_W = 12;
   localparam int PER_W = 16;
   localparam int RES_W = $clog2(PER_W + 1);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    sd_bit = 1'b0;
   logic [PER_W-1:0]        per_len = 16'd250;
   logic                    period_sync = 1'b0;
   logic signed [OUT_W-1:0] sample;
   logic                    sample_valid;
   logic [RES_W-1:0]        eff_bits;

   int total = 0;
   int bad = 0;
   int cur_len = 4;
   bit finished = 0;

   always #2 clk = ~clk;

   sd_comb_decim dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sd_bit      (sd_bit),
      .per_len     (per_len),
      .period_sync (period_sync),
      .sample      (sample),
      .sample_valid(sample_valid),
      .eff_bits    (eff_bits)
   );

   function automatic int clampf(input int v);
      return (v < 4) ? 4 : v;
   endfunction

   function automatic int bits_of(input int v);
      int r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

   function automatic longint exp_word(input int n, input int len);
      longint c, y;
      int r;
      r = bits_of(len);
      c = 2 * longint'(n) - longint'(len);
      if (r <= OUT_W - 1) y = c * (longint'(1) << (OUT_W - 1 - r));
      else                y = c >>> (r - (OUT_W - 1));
      if (y > (longint'(1) << (OUT_W - 1)) - 1) y = (longint'(1) << (OUT_W - 1)) - 1;
      if (y < -(longint'(1) << (OUT_W - 1)))    y = -(longint'(1) << (OUT_W - 1));
      return y;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one full window; mode 0 random, 1 all ones, 2 all zeros
   task automatic run_win(input int plen_sync, input bit do_sync, input int next_plen,
                          input int mode, input string req);
      int len, n, extra;
      bit b;
      len = do_sync ? clampf(plen_sync) : cur_len;
      n = 0;
      extra = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == 0 && do_sync) begin
            per_len = 16'(plen_sync);
            period_sync = 1'b1;
         end else begin
            period_sync = 1'b0;
         end
         if (i == len / 2) per_len = 16'(next_plen);
         b = (mode == 0) ? 1'($urandom % 2) : (mode == 1);
         sd_bit = b;
         n += int'(b);
         @(posedge clk);
         #1;
         if (i < len - 1 && sample_valid) extra++;
      end
      chk(extra == 0, "R3", "early valid count", extra, 0);
      chk(sample_valid == 1'b1, "R3", "valid at window end", sample_valid, 1);
      chk(longint'(sample) == exp_word(n, len), req, "sample", sample, exp_word(n, len));
      chk(int'(eff_bits) == bits_of(len), "R5", "eff_bits", eff_bits, bits_of(len));
      cur_len = clampf(next_plen);
   endtask

   task automatic quiet_bits(input int cnt, input string req);
      int seen = 0;
      for (int i = 0; i < cnt; i++) begin
         @(negedge clk);
         period_sync = 1'b0;
         sd_bit = 1'($urandom % 2);
         @(posedge clk);
         #1;
         if (sample_valid) seen++;
      end
      chk(seen == 0, req, "valid during ignored bits", seen, 0);
   endtask

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sample_valid == 1'b0 && sample == 0 && eff_bits == 0, "R1",
          "reset outputs", {sample_valid, 12'(sample), 5'(eff_bits)}, 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(sample_valid == 1'b0 && sample == 0 && eff_bits == 0, "R1",
          "outputs after release", {sample_valid, 12'(sample), 5'(eff_bits)}, 0);

      // R2: stream before the first strobe is ignored
      quiet_bits(300, "R2");
      chk(sample == 0 && eff_bits == 0, "R2", "sample idle", sample, 0);

      // R4, R6, R5: 100 kHz then 200 kHz windows
      run_win(250, 1, 250, 0, "R4");
      run_win(0, 0, 125, 0, "R6");
      run_win(0, 0, 256, 0, "R5");
      // R7: saturation at both ends
      run_win(0, 0, 256, 1, "R7");
      run_win(0, 0, 256, 2, "R7");
      // R8: clamp short periods
      run_win(2, 1, 3, 1, "R8");
      run_win(0, 0, 100, 0, "R8");
      // R9: mid-window change
      run_win(0, 0, 37, 0, "R9");
      run_win(0, 0, 37, 0, "R9");
      // R10: restart mid-window and on the would-be last bit
      quiet_bits(10, "R10");
      run_win(60, 1, 60, 0, "R10");
      quiet_bits(59, "R10");
      run_win(80, 1, 80, 0, "R10");
      // R11: windows longer than the word resolves
      run_win(5000, 1, 3000, 0, "R11");
      run_win(0, 0, 3000, 1, "R11");
      run_win(0, 0, 700, 2, "R11");

      // constrained random windows with occasional restarts
      for (int k = 0; k < 24; k++) begin
         int nl;
         nl = int'($urandom % 900);
         if (($urandom % 5) == 0) run_win(int'($urandom % 900), 1, nl, 0, "R4");
         else                     run_win(0, 0, nl, int'($urandom % 3), "R6");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule